// File: doc/BRIEF.md
# Image checksum accumulator

This block computes a 16-bit checksum over a programmed memory image while the words stream past. A run starts with a start strobe. Program words then arrive one per cycle with a valid qualifier. A finish request ends the word phase and folds in the configuration term. The checksum comes out with a one-cycle done pulse.

The protect-mode flag is captured at start. In open mode the checksum covers the program words and the masked configuration word. In protected mode the program words are left out, and a value packed from the four user-ID words takes their place. Only the first 2048 words of a run count. If the finish request arrives before all 2048 words have been seen, a shortfall flag is raised.

Top module: `img_checksum_acc`

## Requirements
- R1: With protect low at start, the checksum equals the 16-bit sum of the accepted program words, each zero-extended from 14 bits, plus (cfg_word_i AND 0x0FFF).
- R2: With protect high at start, program words have no effect, and the checksum equals (cfg_word_i AND 0x0FFF) plus the packed ID value.
- R3: The packed ID value puts bits 3:0 of uid0_i in bits 15:12, uid1_i in bits 11:8, uid2_i in bits 7:4 and uid3_i in bits 3:0. For example, IDs 1, 2, 3, 4 give 0x1234.
- R4: Carries out of bit 15 are dropped, so the result is the total modulo 65536.
- R5: Only the first 2048 valid words after start are accepted. Any later words in the same run are ignored.
- R6: Words presented while no run is active do not change the result of the next run, and they do not disturb the checksum output.
- R7: done_o is high for exactly one cycle, on the cycle after the clock edge that samples finish_i during a run. checksum_o changes only together with done_o and holds its value between done pulses.
- R8: count_err_o is set together with done_o if fewer than 2048 words were accepted, cleared if all 2048 were accepted, and cleared by start_i.
- R9: After reset, done_o, checksum_o and count_err_o are 0.
- R10: A start_i during a run discards the partial sum and begins a new run. If start_i and finish_i are high in the same cycle, the start wins.
- R11: finish_i while no run is active produces no done pulse.
- R12: Bits 13:12 of the configuration word never reach the checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a run: clears the sum and the count, and captures protect_i |
| protect_i | input | 1 | Protected-image mode, sampled at start |
| word_vld_i | input | 1 | word_i is valid this cycle |
| word_i | input | 14 | Program word |
| finish_i | input | 1 | End the word phase and add the configuration term |
| cfg_word_i | input | 14 | Configuration word, sampled with finish_i |
| uid0_i | input | 14 | User ID 0 (most significant nibble) |
| uid1_i | input | 14 | User ID 1 |
| uid2_i | input | 14 | User ID 2 |
| uid3_i | input | 14 | User ID 3 (least significant nibble) |
| checksum_o | output | 16 | Registered checksum |
| done_o | output | 1 | One-cycle pulse when checksum_o is updated |
| count_err_o | output | 1 | Run ended with fewer than 2048 words |

## Verification
A word presented in the cycle after the start strobe's edge is the first word that can be accepted. The edge that samples finish_i also registers the checksum, done and the shortfall flag, so all three are due one edge after the finish request. The bench drives every input on the falling edge and reads the outputs at the next falling edge after the edge in question. It then checks one more falling edge later that done has dropped and the checksum has held. Idle-word and idle-finish checks read the outputs after the stimulus, before any later run can change them.

// File: rtl/ckacc_pkg.sv
package ckacc_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;
endpackage

// File: rtl/ckacc_word_counter.sv
module ckacc_word_counter #(
  parameter int WORDS = 2048,
  parameter int CW    = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          full
);
  localparam logic [CW-1:0] LIMIT = CW'(WORDS);

  assign full = (count == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc && !full) count <= count + 1'b1;
  end
endmodule

// File: rtl/ckacc_id_pack.sv
module ckacc_id_pack #(
  parameter int DW   = 14,
  parameter int NID  = 4,
  parameter int NIB  = 4,
  parameter int SW   = NID * NIB
) (
  input  logic [NID-1:0][DW-1:0] ids,
  output logic [SW-1:0]          packed_val
);
  for (genvar g = 0; g < NID; g++) begin : g_nib
    // entry 0 lands in the top nibble
    assign packed_val[(NID-1-g)*NIB +: NIB] = ids[g][NIB-1:0];
  end
endmodule

// File: rtl/ckacc_sum.sv
module ckacc_sum #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          add_en,
  input  logic [SW-1:0] addend,
  output logic [SW-1:0] sum
);
  always_ff @(posedge clk) begin
    if (rst || clr) sum <= '0;
    else if (add_en) sum <= sum + addend;
  end
endmodule

// File: rtl/img_checksum_acc.sv
module img_checksum_acc #(
  parameter int          WORDS    = 2048,
  parameter int          DW       = 14,
  parameter int          SW       = 16,
  parameter int          NID      = 4,
  parameter int          NIB      = 4,
  parameter logic [15:0] CFG_MASK = 16'h0FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          protect_i,
  input  logic          word_vld_i,
  input  logic [DW-1:0] word_i,
  input  logic          finish_i,
  input  logic [DW-1:0] cfg_word_i,
  input  logic [DW-1:0] uid0_i,
  input  logic [DW-1:0] uid1_i,
  input  logic [DW-1:0] uid2_i,
  input  logic [DW-1:0] uid3_i,
  output logic [SW-1:0] checksum_o,
  output logic          done_o,
  output logic          count_err_o
);
  import ckacc_pkg::*;

  localparam int CW  = $clog2(WORDS + 1);
  localparam int PKW = NID * NIB;

  phase_t          phase_q;
  logic            prot_q;
  logic            in_run, fire, accept;
  logic [CW-1:0]   count;
  logic            full;
  logic [SW-1:0]   run_sum, word_ext, cfg_term, id_term, final_sum;
  logic [PKW-1:0]  id_packed;
  logic [NID-1:0][DW-1:0] id_vec;

  assign in_run = (phase_q == PH_RUN);
  assign fire   = in_run && finish_i && !start_i;
  assign accept = in_run && word_vld_i && !finish_i && !start_i && !full;

  assign id_vec = {uid3_i, uid2_i, uid1_i, uid0_i};

  ckacc_word_counter #(.WORDS(WORDS), .CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .clr(start_i), .inc(accept),
    .count(count), .full(full)
  );

  ckacc_id_pack #(.DW(DW), .NID(NID), .NIB(NIB), .SW(PKW)) u_pack (
    .ids(id_vec), .packed_val(id_packed)
  );

  assign word_ext = SW'(word_i);

  ckacc_sum #(.SW(SW)) u_sum (
    .clk(clk), .rst(rst), .clr(start_i),
    .add_en(accept && !prot_q), .addend(word_ext), .sum(run_sum)
  );

  assign cfg_term  = SW'(cfg_word_i) & SW'(CFG_MASK);
  assign id_term   = prot_q ? SW'(id_packed) : '0;
  assign final_sum = (prot_q ? '0 : run_sum) + cfg_term + id_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      prot_q      <= 1'b0;
      checksum_o  <= '0;
      done_o      <= 1'b0;
      count_err_o <= 1'b0;
    end else begin
      done_o <= fire;
      if (start_i) begin
        phase_q     <= PH_RUN;
        prot_q      <= protect_i;
        count_err_o <= 1'b0;
      end else if (fire) begin
        phase_q     <= PH_IDLE;
        checksum_o  <= final_sum;
        count_err_o <= !full;
      end
    end
  end
endmodule

// File: rtl/img_checksum_acc_chk.sv
module img_checksum_acc_chk #(
  parameter int WORDS = 2048,
  parameter int SW    = 16,
  parameter int CW    = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          finish_i,
  input logic [SW-1:0] checksum_o,
  input logic          done_o,
  input logic          count_err_o,
  input logic [CW-1:0] count
);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_needs_finish_R11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(finish_i));

  assert_sum_held_R7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(checksum_o));

  assert_err_moves_R8: assert property (@(posedge clk) disable iff (rst)
    (!done_o && !$past(start_i)) |-> $stable(count_err_o));

  assert_count_cap_R5: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(WORDS));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!done_o && checksum_o == '0 && !count_err_o));
endmodule

bind img_checksum_acc img_checksum_acc_chk #(
  .WORDS(WORDS), .SW(SW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .finish_i(finish_i),
  .checksum_o(checksum_o), .done_o(done_o), .count_err_o(count_err_o),
  .count(count)
);

// File: tb/img_checksum_acc_bench.sv
module img_checksum_acc_bench;
  localparam int NW = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 0, protect_i = 0, word_vld_i = 0, finish_i = 0;
  logic [13:0] word_i = '0, cfg_word_i = '0;
  logic [13:0] uid0_i = '0, uid1_i = '0, uid2_i = '0, uid3_i = '0;
  logic [15:0] checksum_o;
  logic        done_o, count_err_o;

  int n_chk = 0, n_bad = 0;
  bit over = 0;

  always #2 clk = ~clk;

  img_checksum_acc u_img_checksum_acc (
    .clk(clk), .rst(rst), .start_i(start_i), .protect_i(protect_i),
    .word_vld_i(word_vld_i), .word_i(word_i), .finish_i(finish_i),
    .cfg_word_i(cfg_word_i), .uid0_i(uid0_i), .uid1_i(uid1_i),
    .uid2_i(uid2_i), .uid3_i(uid3_i), .checksum_o(checksum_o),
    .done_o(done_o), .count_err_o(count_err_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] wval(int i, int seed);
    logic [31:0] t;
    if (seed == 0) return 14'h3FFF;
    t = (i * 131 + seed) ^ (i >> 3);
    return t[13:0];
  endfunction

  function automatic logic [15:0] wsum(int n, int seed);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s += 16'(wval(i, seed));
    return s;
  endfunction

  task automatic do_start(bit prot);
    @(negedge clk); start_i = 1; protect_i = prot;
    @(negedge clk); start_i = 0; protect_i = 0;
  endtask

  task automatic feed(int n, int seed);
    for (int i = 0; i < n; i++) begin
      word_vld_i = 1; word_i = wval(i, seed);
      @(negedge clk);
    end
    word_vld_i = 0; word_i = '0;
  endtask

  // pulse finish, then check the outputs on the next two falling edges
  task automatic finish_chk(string req, logic [13:0] cfg, logic [15:0] exp,
                            bit exp_err);
    finish_i = 1; cfg_word_i = cfg;
    @(negedge clk); finish_i = 0;
    chk({req, " done"}, done_o, 1);
    chk({req, " checksum"}, checksum_o, exp);
    chk({req, " count_err"}, count_err_o, exp_err);
    @(negedge clk);
    chk({req, " done drops R7"}, done_o, 0);
    chk({req, " checksum holds R7"}, checksum_o, exp);
  endtask

  task automatic t_reset;
    chk("R9 done", done_o, 0);
    chk("R9 checksum", checksum_o, 0);
    chk("R9 count_err", count_err_o, 0);
  endtask

  task automatic t_plain; // R1, R12
    do_start(0);
    feed(NW, 5);
    finish_chk("R1 R12", 14'h3ABC, wsum(NW, 5) + 16'h0ABC, 0);
  endtask

  task automatic t_protect; // R2, R3
    uid0_i = 14'h3FF1; uid1_i = 14'h0022; uid2_i = 14'h1003; uid3_i = 14'h0004;
    do_start(1);
    feed(NW, 9);
    finish_chk("R2 R3", 14'h0100, 16'h1234 + 16'h0100, 0);
    uid0_i = 14'h000A; uid1_i = 14'h000B; uid2_i = 14'h000C; uid3_i = 14'h000D;
    do_start(1);
    feed(NW, 3);
    finish_chk("R3 pack", 14'h2FFF, 16'hABCD + 16'h0FFF, 0);
  endtask

  task automatic t_wrap; // R4
    do_start(0);
    feed(NW, 0);
    finish_chk("R4", 14'h3FFF, 16'h07FF, 0);
  endtask

  task automatic t_extra; // R5
    do_start(0);
    feed(NW + 2, 17);
    finish_chk("R5", 14'h0001, wsum(NW, 17) + 16'h0001, 0);
  endtask

  task automatic t_idle; // R6
    logic [15:0] held;
    held = checksum_o;
    feed(20, 11);
    chk("R6 idle words no effect", checksum_o, held);
    chk("R6 idle words no done", done_o, 0);
    do_start(0);
    feed(NW, 23);
    finish_chk("R6 next run", 14'h0123, wsum(NW, 23) + 16'h0123, 0);
  endtask

  task automatic t_short; // R8
    do_start(0);
    feed(10, 7);
    finish_chk("R8 short", 14'h0042, wsum(10, 7) + 16'h0042, 1);
    do_start(0);
    chk("R8 cleared by start", count_err_o, 0);
    feed(NW, 7);
    finish_chk("R8 full", 14'h0042, wsum(NW, 7) + 16'h0042, 0);
  endtask

  task automatic t_fin_idle; // R11
    logic [15:0] held;
    held = checksum_o;
    finish_i = 1;
    @(negedge clk); finish_i = 0;
    chk("R11 no done", done_o, 0);
    chk("R11 checksum held", checksum_o, held);
  endtask

  task automatic t_restart; // R10
    do_start(0);
    feed(30, 13);
    do_start(0);
    feed(NW, 29);
    finish_chk("R10 restart", 14'h0555, wsum(NW, 29) + 16'h0555, 0);
    do_start(0);
    feed(NW, 29);
    finish_i = 1; start_i = 1;
    @(negedge clk); finish_i = 0; start_i = 0;
    chk("R10 start wins", done_o, 0);
    feed(NW, 31);
    finish_chk("R10 after tie", 14'h0010, wsum(NW, 31) + 16'h0010, 0);
  endtask

  task automatic summary;
    if (!over) begin
      over = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_plain;
    t_protect;
    t_wrap;
    t_extra;
    t_idle;
    t_short;
    t_fin_idle;
    t_restart;
    summary;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end
endmodule